// File: doc/BRIEF.md
# Banked Internal Data RAM

This block is the 128-byte on-chip data store of a small 8-bit controller. It can be reached in three ways during one clock cycle. A byte port reads and writes any of the 128 locations. A register port takes a 3-bit working-register number and places it in one of four eight-byte banks at the bottom of the memory. A bit port reads, sets or clears a single bit in the 16-byte bit-addressable window that starts at 20H.

The active bank is given by a 2-bit input. The status register that holds these bits is outside the block, so the core drives the input directly. All reads are registered and take one cycle. A read that happens in the same cycle as a write to the same byte returns the old content. Writes from different ports to different bytes all take effect in the same cycle. When several writes target one byte, a fixed priority decides which one is stored.

The bytes from 30H to 7FH hold no special function. They are plain scratch storage, reached only through the byte port.

Top module: `idram_bank_ram`

## Requirements
- R1: A byte write stores `byte_wdata` at `byte_addr`, for any address 00H to 7FH. A byte read with `byte_en` high and `byte_we` low returns that byte on `byte_rdata` one clock after the request.
- R2: Each read output changes only on a clock edge at which its port's enable is high. While the enable is low, the output holds its last value.
- R3: The register port uses the physical address {bank_sel[1:0], reg_num[2:0]}. For example, R0 is 00H in bank 0, 08H in bank 1, 10H in bank 2 and 18H in bank 3. The port reads and writes that byte with one cycle of read latency.
- R4: The bank is taken from `bank_sel` in the cycle of each register access. The same register number read under another bank returns that bank's byte.
- R5: A 7-bit bit address selects byte 20H + bit_addr[6:3] and bit position bit_addr[2:0] within that byte, with 0 as the least significant bit. A bit read returns that bit on `bit_rdata` one clock later.
- R6: A bit write sets the selected bit to `bit_wval` and leaves the other seven bits of that byte unchanged.
- R7: A byte read or register read of a byte in 20H to 2FH returns all eight bits, including bits changed earlier by bit writes.
- R8: When several writes target the same byte in one cycle, the byte port wins over the register port and the bit port. Only the byte port's data is stored.
- R9: A read in the same cycle as a write to the same byte returns the content from before that write.
- R10: While `rst_n` is low at a clock edge, every byte is cleared to 00H and all three read outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_sel | input | 2 | Active register bank, from the status register |
| byte_en | input | 1 | Byte port access request |
| byte_we | input | 1 | Byte port write (1) or read (0) |
| byte_addr | input | 7 | Byte port address |
| byte_wdata | input | 8 | Byte port write data |
| byte_rdata | output | 8 | Byte port read data, one cycle after the request |
| reg_en | input | 1 | Register port access request |
| reg_we | input | 1 | Register port write (1) or read (0) |
| reg_num | input | 3 | Working register number |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data |
| bit_en | input | 1 | Bit port access request |
| bit_we | input | 1 | Bit port write (1) or read (0) |
| bit_addr | input | 7 | Bit address inside the bit window |
| bit_wval | input | 1 | Value written to the selected bit |
| bit_rdata | output | 1 | Bit port read value |

## Verification
The assertions assume that every input is known at each rising edge, and that reset is held for at least one edge before the first access. The bench drives each input pattern half a period before the edge that samples it. The write-then-read properties apply only when the intervening write was not overridden by a higher-priority byte write to the same byte. The random stimulus often aims the byte port at the byte that the bit or register port is touching, so that collisions and read-during-write cases occur often. A few directed cycles also force those cases.

// File: rtl/idram_pkg.sv
// Package: shared sizes for the banked internal data RAM.
// Assumes an 8-bit data path and a bit window that fits below RAM_BYTES.
package idram_pkg;
    localparam int unsigned RAM_BYTES = 128;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned BANK_W    = 2;
    localparam int unsigned REGN_W    = 3;
    localparam int unsigned BIT_BASE  = 32;
endpackage

// File: rtl/idram_addr_map.sv
// Address mapper: turns a register number plus bank into a physical byte
// address, and a bit address into a byte address plus bit position.
// Assumes BANK_W + REGN_W <= AW and that the bit window fits in the memory.
module idram_addr_map #(
    parameter int unsigned AW       = 7,
    parameter int unsigned BANK_W   = 2,
    parameter int unsigned REGN_W   = 3,
    parameter int unsigned POS_W    = 3,
    parameter int unsigned BIT_BASE = 32
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [REGN_W-1:0] reg_num,
    input  logic [AW-1:0]     bit_addr,
    output logic [AW-1:0]     reg_phys,
    output logic [AW-1:0]     bit_byte,
    output logic [POS_W-1:0]  bit_pos
);
    localparam int unsigned PAD_W = AW - BANK_W - REGN_W;

    // Register address: bank bits on top of the register number.
    if (PAD_W > 0) begin : g_pad
        assign reg_phys = {{PAD_W{1'b0}}, bank, reg_num};
    end else begin : g_nopad
        assign reg_phys = {bank, reg_num};
    end

    // Bit address: upper bits pick a byte in the window, lower bits the bit.
    assign bit_byte = AW'(BIT_BASE) + AW'(bit_addr[AW-1:POS_W]);
    assign bit_pos  = bit_addr[POS_W-1:0];
endmodule

// File: rtl/idram_row.sv
// One storage byte. It applies at most one write per cycle, with the byte
// port first, then the register port, then a single-bit update.
// Assumes the hit inputs are already qualified by their port's write enable.
module idram_row #(
    parameter int unsigned DW    = 8,
    parameter int unsigned POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_byte,
    input  logic [DW-1:0]    byte_data,
    input  logic             hit_reg,
    input  logic [DW-1:0]    reg_data,
    input  logic             hit_bit,
    input  logic [POS_W-1:0] bit_pos,
    input  logic             bit_val,
    output logic [DW-1:0]    q
);
    // Prioritised write, with a read-modify-write for the bit port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (hit_byte) begin
            q <= byte_data;
        end else if (hit_reg) begin
            q <= reg_data;
        end else if (hit_bit) begin
            q[bit_pos] <= bit_val;
        end
    end
endmodule

// File: rtl/idram_read_port.sv
// Registered read port: on an enabled cycle, captures the addressed byte
// from the flattened storage vector; otherwise holds its output.
// Assumes addr < DEPTH.
module idram_read_port #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [AW-1:0]       addr,
    input  logic [DEPTH*DW-1:0] flat,
    output logic [DW-1:0]       rdata
);
    // Capture the old content of the selected byte on an enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en) begin
            rdata <= flat[addr*DW +: DW];
        end
    end
endmodule

// File: rtl/idram_bank_ram.sv
// Top of the banked internal data RAM: a byte port, a banked register port
// and a single-bit port over one flop-based array, with registered reads.
// Assumes the status-register bank bits arrive already decoded as bank_sel.
module idram_bank_ram
    import idram_pkg::*;
#(
    parameter int unsigned DEPTH = RAM_BYTES,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned BW    = BANK_W,
    parameter int unsigned RW    = REGN_W,
    parameter int unsigned BBASE = BIT_BASE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BW-1:0]            bank_sel,
    input  logic                     byte_en,
    input  logic                     byte_we,
    input  logic [$clog2(DEPTH)-1:0] byte_addr,
    input  logic [DW-1:0]            byte_wdata,
    output logic [DW-1:0]            byte_rdata,
    input  logic                     reg_en,
    input  logic                     reg_we,
    input  logic [RW-1:0]            reg_num,
    input  logic [DW-1:0]            reg_wdata,
    output logic [DW-1:0]            reg_rdata,
    input  logic                     bit_en,
    input  logic                     bit_we,
    input  logic [$clog2(DEPTH)-1:0] bit_addr,
    input  logic                     bit_wval,
    output logic                     bit_rdata
);
    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned POS_W = $clog2(DW);

    logic [AW-1:0]       reg_phys;
    logic [AW-1:0]       bit_byte;
    logic [POS_W-1:0]    bit_pos;
    logic [DEPTH*DW-1:0] flat;
    logic [DW-1:0]       bit_byte_q;
    logic [POS_W-1:0]    bit_pos_q;
    logic                byte_wr, reg_wr, bit_wr;

    assign byte_wr = byte_en && byte_we;
    assign reg_wr  = reg_en && reg_we;
    assign bit_wr  = bit_en && bit_we;

    idram_addr_map #(
        .AW(AW), .BANK_W(BW), .REGN_W(RW), .POS_W(POS_W), .BIT_BASE(BBASE)
    ) i_map (
        .bank(bank_sel), .reg_num(reg_num), .bit_addr(bit_addr),
        .reg_phys(reg_phys), .bit_byte(bit_byte), .bit_pos(bit_pos)
    );

    // One storage row per byte, each decoding its own write hits.
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [DW-1:0] q;
        idram_row #(.DW(DW), .POS_W(POS_W)) i_row (
            .clk(clk), .rst_n(rst_n),
            .hit_byte(byte_wr && (byte_addr == AW'(g))), .byte_data(byte_wdata),
            .hit_reg(reg_wr && (reg_phys == AW'(g))),    .reg_data(reg_wdata),
            .hit_bit(bit_wr && (bit_byte == AW'(g))),    .bit_pos(bit_pos),
            .bit_val(bit_wval), .q(q)
        );
        assign flat[g*DW +: DW] = q;
    end

    idram_read_port #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) i_rd_byte (
        .clk(clk), .rst_n(rst_n), .en(byte_en && !byte_we), .addr(byte_addr),
        .flat(flat), .rdata(byte_rdata)
    );

    idram_read_port #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) i_rd_reg (
        .clk(clk), .rst_n(rst_n), .en(reg_en && !reg_we), .addr(reg_phys),
        .flat(flat), .rdata(reg_rdata)
    );

    idram_read_port #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) i_rd_bit (
        .clk(clk), .rst_n(rst_n), .en(bit_en && !bit_we), .addr(bit_byte),
        .flat(flat), .rdata(bit_byte_q)
    );

    // Bit position travels alongside the captured byte of the bit read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_pos_q <= '0;
        end else if (bit_en && !bit_we) begin
            bit_pos_q <= bit_pos;
        end
    end

    assign bit_rdata = bit_byte_q[bit_pos_q];
endmodule

// File: rtl/idram_bank_ram_chk.sv
// Checker for idram_bank_ram: write-then-read properties per port, output
// hold while idle, and reset clearing. Assumes default widths (7-bit address).
module idram_bank_ram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bank_sel,
    input logic       byte_en,
    input logic       byte_we,
    input logic [6:0] byte_addr,
    input logic [7:0] byte_wdata,
    input logic [7:0] byte_rdata,
    input logic       reg_en,
    input logic       reg_we,
    input logic [2:0] reg_num,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       bit_en,
    input logic       bit_we,
    input logic [6:0] bit_addr,
    input logic       bit_wval,
    input logic       bit_rdata
);
    logic       bw_v, rw_v, tw_v;
    logic [6:0] bw_a, rw_a, tw_a;
    logic [7:0] bw_d, rw_d;
    logic       tw_d;
    logic [6:0] rw_phys, tw_byte;

    assign rw_phys = {2'b00, bank_sel, reg_num};
    assign tw_byte = 7'h20 + {3'b000, bit_addr[6:3]};

    // Remember last cycle's effective writes per port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_v <= 1'b0; rw_v <= 1'b0; tw_v <= 1'b0;
            bw_a <= '0; rw_a <= '0; tw_a <= '0;
            bw_d <= '0; rw_d <= '0; tw_d <= 1'b0;
        end else begin
            bw_v <= byte_en && byte_we;
            bw_a <= byte_addr;
            bw_d <= byte_wdata;
            rw_v <= reg_en && reg_we && !(byte_en && byte_we && byte_addr == rw_phys);
            rw_a <= rw_phys;
            rw_d <= reg_wdata;
            tw_v <= bit_en && bit_we && !(byte_en && byte_we && byte_addr == tw_byte);
            tw_a <= bit_addr;
            tw_d <= bit_wval;
        end
    end

    AST_BYTE_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_v && byte_en && !byte_we && byte_addr == bw_a) |=> byte_rdata == $past(bw_d)); // R1

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> $stable(byte_rdata)); // R2

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |=> $stable(reg_rdata)); // R2

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(bit_rdata)); // R2

    AST_REG_BANK_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_v && byte_en && !byte_we && byte_addr == rw_a) |=> byte_rdata == $past(rw_d)); // R3

    AST_BIT_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_v && bit_en && !bit_we && bit_addr == tw_a) |=> bit_rdata == $past(tw_d)); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (byte_rdata == 8'h00 && reg_rdata == 8'h00 && !bit_rdata)); // R10
endmodule

bind idram_bank_ram idram_bank_ram_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .byte_en(byte_en), .byte_we(byte_we), .byte_addr(byte_addr),
    .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
    .reg_en(reg_en), .reg_we(reg_we), .reg_num(reg_num),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_en(bit_en), .bit_we(bit_we), .bit_addr(bit_addr),
    .bit_wval(bit_wval), .bit_rdata(bit_rdata)
);

// File: tb/test_idram_bank_ram.sv
`timescale 1ns/1ps
// Bench for idram_bank_ram: directed corner cases, then seeded random
// traffic checked against a byte-array model kept by the bench.
module test_idram_bank_ram;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bank_sel;
    logic       byte_en, byte_we;
    logic [6:0] byte_addr;
    logic [7:0] byte_wdata, byte_rdata;
    logic       reg_en, reg_we;
    logic [2:0] reg_num;
    logic [7:0] reg_wdata, reg_rdata;
    logic       bit_en, bit_we;
    logic [6:0] bit_addr;
    logic       bit_wval, bit_rdata;

    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    logic [7:0] mem_m [128];
    logic [7:0] exp_byte, exp_reg;
    logic       exp_bit;

    always #2.5 clk = ~clk;

    idram_bank_ram i_idram_bank_ram (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .byte_en(byte_en), .byte_we(byte_we), .byte_addr(byte_addr),
        .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
        .reg_en(reg_en), .reg_we(reg_we), .reg_num(reg_num),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_en(bit_en), .bit_we(bit_we), .bit_addr(bit_addr),
        .bit_wval(bit_wval), .bit_rdata(bit_rdata)
    );

    function automatic logic [6:0] f_reg_phys(input logic [1:0] b, input logic [2:0] r);
        return {2'b00, b, r};
    endfunction

    function automatic logic [6:0] f_bit_byte(input logic [6:0] a);
        return 7'h20 + {3'b000, a[6:3]};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        byte_en = 1'b0; byte_we = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
        bit_en = 1'b0; bit_we = 1'b0;
    endtask

    // One clock: compute expected reads from the old model, apply writes in
    // priority order (lowest first), then check all outputs after the edge.
    task automatic step();
        logic [6:0] rp, bb;
        rp = f_reg_phys(bank_sel, reg_num);
        bb = f_bit_byte(bit_addr);
        if (byte_en && !byte_we) exp_byte = mem_m[byte_addr];
        if (reg_en && !reg_we)   exp_reg  = mem_m[rp];
        if (bit_en && !bit_we)   exp_bit  = mem_m[bb][bit_addr[2:0]];
        if (bit_en && bit_we)    mem_m[bb][bit_addr[2:0]] = bit_wval;
        if (reg_en && reg_we)    mem_m[rp] = reg_wdata;
        if (byte_en && byte_we)  mem_m[byte_addr] = byte_wdata;
        @(posedge clk);
        @(negedge clk);
        chk((byte_en && !byte_we) ? "R1" : "R2", byte_rdata, exp_byte, "byte_rdata");
        chk((reg_en && !reg_we) ? "R3" : "R2", reg_rdata, exp_reg, "reg_rdata");
        chk((bit_en && !bit_we) ? "R5" : "R2", {7'b0, bit_rdata}, {7'b0, exp_bit}, "bit_rdata");
    endtask

    task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
        idle(); byte_en = 1'b1; byte_we = 1'b1; byte_addr = a; byte_wdata = d; step();
    endtask

    task automatic rd_byte(input logic [6:0] a);
        idle(); byte_en = 1'b1; byte_addr = a; step();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mem_m[i] = 8'h00;
        exp_byte = 8'h00; exp_reg = 8'h00; exp_bit = 1'b0;
        rst_n = 1'b0; bank_sel = 2'd0; byte_addr = '0; byte_wdata = '0;
        reg_num = '0; reg_wdata = '0; bit_addr = '0; bit_wval = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", byte_rdata, 8'h00, "byte_rdata in reset");
        chk("R10", reg_rdata, 8'h00, "reg_rdata in reset");
        chk("R10", {7'b0, bit_rdata}, 8'h00, "bit_rdata in reset");
        rst_n = 1'b1;

        // R10: contents cleared at both ends of the memory.
        rd_byte(7'h00); chk("R10", byte_rdata, 8'h00, "byte 00H after reset");
        rd_byte(7'h7F); chk("R10", byte_rdata, 8'h00, "byte 7FH after reset");

        // R1: scratch area write then read.
        wr_byte(7'h55, 8'hC3); rd_byte(7'h55); chk("R1", byte_rdata, 8'hC3, "scratch 55H");

        // R3: R0 of each bank lands on bank*8.
        for (int b = 0; b < 4; b++) begin
            idle(); bank_sel = 2'(b); reg_en = 1'b1; reg_we = 1'b1; reg_num = 3'd0;
            reg_wdata = 8'hA0 + 8'(b); step();
            rd_byte(7'(b * 8));
            chk("R3", byte_rdata, 8'hA0 + 8'(b), "bank R0 physical byte");
        end

        // R4: same register number under different banks reads different bytes.
        idle(); bank_sel = 2'd3; reg_en = 1'b1; reg_num = 3'd0; step();
        chk("R4", reg_rdata, 8'hA3, "bank 3 R0");
        idle(); bank_sel = 2'd1; reg_en = 1'b1; reg_num = 3'd0; step();
        chk("R4", reg_rdata, 8'hA1, "bank 1 R0");

        // R6 and R7: bit updates keep the neighbours and show on byte reads.
        wr_byte(7'h25, 8'h5A);
        idle(); bit_en = 1'b1; bit_we = 1'b1; bit_addr = 7'h28; bit_wval = 1'b1; step();
        rd_byte(7'h25); chk("R6", byte_rdata, 8'h5B, "bit 0 set in 25H");
        idle(); bit_en = 1'b1; bit_we = 1'b1; bit_addr = 7'h2E; bit_wval = 1'b0; step();
        rd_byte(7'h25); chk("R7", byte_rdata, 8'h1B, "bit 6 cleared in 25H");
        idle(); bit_en = 1'b1; bit_addr = 7'h2B; step();
        chk("R5", {7'b0, bit_rdata}, 8'h01, "bit 3 of 25H");

        // R8: byte write wins over a bit write and a register write.
        idle(); byte_en = 1'b1; byte_we = 1'b1; byte_addr = 7'h2A; byte_wdata = 8'hF0;
        bit_en = 1'b1; bit_we = 1'b1; bit_addr = 7'h50; bit_wval = 1'b1; step();
        rd_byte(7'h2A); chk("R8", byte_rdata, 8'hF0, "byte vs bit collision");
        idle(); byte_en = 1'b1; byte_we = 1'b1; byte_addr = 7'h0B; byte_wdata = 8'h3C;
        bank_sel = 2'd1; reg_en = 1'b1; reg_we = 1'b1; reg_num = 3'd3; reg_wdata = 8'h99; step();
        rd_byte(7'h0B); chk("R8", byte_rdata, 8'h3C, "byte vs reg collision");

        // R9: reads see old content while the byte port overwrites it.
        idle(); byte_en = 1'b1; byte_we = 1'b1; byte_addr = 7'h0B; byte_wdata = 8'h77;
        reg_en = 1'b1; reg_num = 3'd3; bit_en = 1'b1; bit_addr = 7'h50; step();
        chk("R9", reg_rdata, 8'h3C, "reg read during byte write");
        chk("R9", {7'b0, bit_rdata}, 8'h00, "bit read during byte write");

        // R2: outputs hold while enables are low and addresses move.
        idle(); byte_addr = 7'h00; reg_num = 3'd5; bit_addr = 7'h00; step();
        chk("R2", reg_rdata, 8'h3C, "reg_rdata held");

        // Seeded random traffic with biased collisions.
        void'($urandom(32'h1D5A));
        for (int n = 0; n < 4000; n++) begin
            bank_sel   = 2'($urandom);
            byte_en    = 1'($urandom); byte_we = 1'($urandom);
            byte_addr  = 7'($urandom); byte_wdata = 8'($urandom);
            reg_en     = 1'($urandom); reg_we = 1'($urandom);
            reg_num    = 3'($urandom); reg_wdata = 8'($urandom);
            bit_en     = 1'($urandom); bit_we = 1'($urandom);
            bit_addr   = 7'($urandom); bit_wval = 1'($urandom);
            case ($urandom % 4)
                0: byte_addr = f_bit_byte(bit_addr);
                1: byte_addr = f_reg_phys(bank_sel, reg_num);
                default: ;
            endcase
            step();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule